// File: doc/BRIEF.md
# ATA Port Routing Crossbar

This block sits between two parallel ATA host controllers and three kinds of downstream endpoint: two serial bridge adapters and one set of external IDE pads. The pads have two slots, one for a master device and one for a slave device. Each controller has a master port and a slave port, so there are four host-side ports in total. A 3-bit routing code, held in a 32-bit control register, picks one of four connection patterns. In some patterns a bridge serves as the slave drive of the other controller, and the controller left over goes out to the pads.

From the latched code and two global enables, the block works out several things. It decides which host port each endpoint carries and whether each controller has a bridge behind it. It also decides whether each bridge should present itself as a slave device. Ports and endpoints that nothing is routed to see an all-zero word, which means every handshake line is deasserted. A reserved code, or both enables low, puts the block in a fault state in which nothing is routed.

A small state machine holds the decision. ST_IDLE is the state after reset, with no routing and no fault. ST_ROUTE applies the routing pattern. ST_FAULT applies no routing and raises the error flag. On every clock, from any of the three states, the next state is ST_ROUTE when the code is valid and at least one enable is set, and ST_FAULT otherwise.

Top module: `ata_lane_router`

## Requirements
- R1: The control register is 32 bits wide, sits at address 0x30 and resets to zero. A write at 0x30 replaces only the bits set in the write mask and keeps every other bit. A write at any other address changes nothing. The read data shows the register at 0x30 and zero at any other address. The routing code is held in bits 26:24.
- R2: While reset is held, and in the first cycle after it, the block routes nothing and the error flag is low.
- R3: The routing outputs follow the code and the enables one clock after they are sampled. A register write therefore shows on the routing outputs two clocks after it is presented.
- R4: Code 000 routes controller-0 master to bridge 0 and controller-1 master to bridge 1. It routes controller-0 slave to the pad slave slot and leaves the pad master slot empty.
- R5: Code 001 makes the same bridge connections as code 000, but routes controller-1 slave to the pad slave slot. The pad master slot stays empty.
- R6: Code 010 routes controller-1 master to bridge 1 and controller-1 slave to bridge 0. It routes controller-0 master to the pad master slot and controller-0 slave to the pad slave slot.
- R7: Code 011 routes controller-0 master to bridge 0 and controller-0 slave to bridge 1. It routes controller-1 master to the pad master slot and controller-1 slave to the pad slave slot.
- R8: Codes 100 to 111 raise the error flag, route nothing, and clear both the bridge-present and the slave flags.
- R9: When the bridge enable and the pad enable are both low, the error flag is raised and nothing is routed.
- R10: With the bridge enable low, neither bridge endpoint is routed, and the bridge-present and slave flags are all low.
- R11: With the pad enable low, neither pad slot is routed.
- R12: Every host port and endpoint that is not routed sees an all-zero word. No host port is connected to more than one endpoint.
- R13: While routing with the bridge enable set, the bridge-present flag (bit 0 for controller 0, bit 1 for controller 1) is low only for controller 0 under code 010 and only for controller 1 under code 011. The slave flag is high only for bridge 0 under code 010 and only for bridge 1 under code 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wmask | input | 32 | Per-bit write mask |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data |
| bridge_en | input | 1 | Global enable for the bridge function |
| pad_en | input | 1 | Enable for routing to the IDE pads |
| port_h2d | input | 4*DATA_W | Host-to-device words; slice 0 is c0 master, 1 is c0 slave, 2 is c1 master, 3 is c1 slave |
| port_d2h | output | 4*DATA_W | Device-to-host words, with the same slice order |
| ep_h2d | output | 4*DATA_W | Words to the endpoints; slice 0 is bridge 0, 1 is bridge 1, 2 is pad master, 3 is pad slave |
| ep_d2h | input | 4*DATA_W | Words from the endpoints, with the same slice order |
| ctl_has_bridge | output | 2 | Bridge present behind controller 0 (bit 0) and controller 1 (bit 1) |
| bridge_slave | output | 2 | Bridge 0 (bit 0) or bridge 1 (bit 1) should act as a slave device |
| cfg_err | output | 1 | Invalid configuration |

## Verification
The bench builds the block with DATA_W set to 10 and keeps the default register address and field position. A narrow word keeps each random value cheap, yet still wide enough that a wrong slice selection almost always produces a different word at some endpoint. Every one of the eight codes is combined with all four enable settings, so each valid pattern, each reserved code and each fault cause is reached within a few hundred cycles. Masked writes and writes at other addresses exercise the field update alongside the routing.

// File: rtl/ata_route_pkg.sv
package ata_route_pkg;

    localparam int NPORT  = 4;
    localparam int NEP    = 4;
    localparam int MODE_W = 3;
    localparam int NUM_MODES = 4;

    typedef logic [2:0] src_t;
    localparam src_t SRC_NONE = 3'd0;
    localparam src_t SRC_C0M  = 3'd1;
    localparam src_t SRC_C0S  = 3'd2;
    localparam src_t SRC_C1M  = 3'd3;
    localparam src_t SRC_C1S  = 3'd4;

    localparam int EP_BR0  = 0;
    localparam int EP_BR1  = 1;
    localparam int EP_PADM = 2;
    localparam int EP_PADS = 3;

    localparam logic [MODE_W-1:0] MD_PAD_C0S = 3'd0;
    localparam logic [MODE_W-1:0] MD_PAD_C1S = 3'd1;
    localparam logic [MODE_W-1:0] MD_C1_DUAL = 3'd2;
    localparam logic [MODE_W-1:0] MD_C0_DUAL = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUTE = 2'd1,
        ST_FAULT = 2'd2
    } rt_state_e;

endpackage

// File: rtl/ata_route_ctrlreg.sv
module ata_route_ctrlreg
    import ata_route_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h30,
    parameter int MODE_LSB = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wmask,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [MODE_W-1:0] mode
);

    logic [REG_W-1:0] ctrl_q;
    logic             hit;

    assign hit = (cfg_addr == CTRL_OFFSET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_wr && hit) begin
            ctrl_q <= (ctrl_q & ~cfg_wmask) | (cfg_wdata & cfg_wmask);
        end
    end

    assign cfg_rdata = hit ? ctrl_q : '0;
    assign mode      = ctrl_q[MODE_LSB +: MODE_W];

    // R1: a write at another address leaves the register alone
    a_r1_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !hit) |=> $stable(ctrl_q));

    // R1: bits outside the mask survive any write
    a_r1_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ((ctrl_q & ~$past(cfg_wmask)) == ($past(ctrl_q) & ~$past(cfg_wmask))));

endmodule

// File: rtl/ata_route_fsm.sv
module ata_route_fsm
    import ata_route_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MODE_W-1:0]     mode,
    input  logic                  bridge_en,
    input  logic                  pad_en,
    output logic [NEP-1:0][2:0]   sel,
    output logic [1:0]            has_bridge,
    output logic [1:0]            br_slave,
    output logic                  cfg_err
);

    localparam logic [MODE_W-1:0] MODE_CNT = MODE_W'(NUM_MODES);

    rt_state_e         state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic              bren_q;
    logic              paden_q;
    logic              cfg_ok;

    assign cfg_ok = (mode < MODE_CNT) && (bridge_en || pad_en);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = cfg_ok ? ST_ROUTE : ST_FAULT;
            ST_ROUTE: state_d = cfg_ok ? ST_ROUTE : ST_FAULT;
            ST_FAULT: state_d = cfg_ok ? ST_ROUTE : ST_FAULT;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            bren_q  <= 1'b0;
            paden_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode;
            bren_q  <= bridge_en;
            paden_q <= pad_en;
        end
    end

    always_comb begin
        sel        = '0;
        has_bridge = 2'b00;
        br_slave   = 2'b00;
        cfg_err    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ROUTE: begin
                if (bren_q) begin
                    has_bridge[0] = (mode_q != MD_C1_DUAL);
                    has_bridge[1] = (mode_q != MD_C0_DUAL);
                    br_slave[0]   = (mode_q == MD_C1_DUAL);
                    br_slave[1]   = (mode_q == MD_C0_DUAL);
                    sel[EP_BR0]   = (mode_q == MD_C1_DUAL) ? SRC_C1S : SRC_C0M;
                    sel[EP_BR1]   = (mode_q == MD_C0_DUAL) ? SRC_C0S : SRC_C1M;
                end
                if (paden_q) begin
                    unique case (mode_q)
                        MD_PAD_C0S: sel[EP_PADS] = SRC_C0S;
                        MD_PAD_C1S: sel[EP_PADS] = SRC_C1S;
                        MD_C1_DUAL: begin
                            sel[EP_PADM] = SRC_C0M;
                            sel[EP_PADS] = SRC_C0S;
                        end
                        MD_C0_DUAL: begin
                            sel[EP_PADM] = SRC_C1M;
                            sel[EP_PADS] = SRC_C1S;
                        end
                        default: begin
                        end
                    endcase
                end
            end
            ST_FAULT: cfg_err = 1'b1;
            default: begin
            end
        endcase
    end

    a_r8_reserved_code_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= MODE_CNT) |=> (cfg_err && sel == '0 && has_bridge == 2'b00 && br_slave == 2'b00));

    a_r9_no_enable_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (!bridge_en && !pad_en) |=> (cfg_err && sel == '0));

    a_r10_bridge_off: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_en |=> (has_bridge == 2'b00 && br_slave == 2'b00
                        && sel[EP_BR0] == SRC_NONE && sel[EP_BR1] == SRC_NONE));

    a_r11_pad_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_en |=> (sel[EP_PADM] == SRC_NONE && sel[EP_PADS] == SRC_NONE));

    // R13: a bridge acting as slave leaves its own controller without a bridge
    a_r13_slave0_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        br_slave[0] |-> (!has_bridge[0] && has_bridge[1] && !br_slave[1]));

    a_r13_slave1_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        br_slave[1] |-> (!has_bridge[1] && has_bridge[0] && !br_slave[0]));

endmodule

// File: rtl/ata_route_xbar.sv
module ata_route_xbar
    import ata_route_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NEP-1:0][2:0]     sel,
    input  logic [NPORT*DATA_W-1:0] port_h2d,
    output logic [NPORT*DATA_W-1:0] port_d2h,
    output logic [NEP*DATA_W-1:0]   ep_h2d,
    input  logic [NEP*DATA_W-1:0]   ep_d2h
);

    logic [NPORT-1:0][NEP-1:0] own;

    for (genvar p = 0; p < NPORT; p++) begin : g_own
        for (genvar e = 0; e < NEP; e++) begin : g_ep
            assign own[p][e] = (sel[e] == 3'(p + 1));
        end
    end

    for (genvar e = 0; e < NEP; e++) begin : g_down
        always_comb begin
            ep_h2d[e*DATA_W +: DATA_W] = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (own[p][e]) begin
                    ep_h2d[e*DATA_W +: DATA_W] = ep_h2d[e*DATA_W +: DATA_W] | port_h2d[p*DATA_W +: DATA_W];
                end
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_up
        always_comb begin
            port_d2h[p*DATA_W +: DATA_W] = '0;
            for (int e = 0; e < NEP; e++) begin
                if (own[p][e]) begin
                    port_d2h[p*DATA_W +: DATA_W] = port_d2h[p*DATA_W +: DATA_W] | ep_d2h[e*DATA_W +: DATA_W];
                end
            end
        end

        a_r12_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own[p]));
    end

endmodule

// File: rtl/ata_lane_router.sv
module ata_lane_router
    import ata_route_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h30,
    parameter int MODE_LSB = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wmask,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    input  logic                    bridge_en,
    input  logic                    pad_en,
    input  logic [NPORT*DATA_W-1:0] port_h2d,
    output logic [NPORT*DATA_W-1:0] port_d2h,
    output logic [NEP*DATA_W-1:0]   ep_h2d,
    input  logic [NEP*DATA_W-1:0]   ep_d2h,
    output logic [1:0]              ctl_has_bridge,
    output logic [1:0]              bridge_slave,
    output logic                    cfg_err
);

    logic [MODE_W-1:0]   mode;
    logic [NEP-1:0][2:0] sel;

    ata_route_ctrlreg #(
        .REG_W      (32),
        .ADDR_W     (ADDR_W),
        .CTRL_OFFSET(CTRL_OFFSET),
        .MODE_LSB   (MODE_LSB)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wmask (cfg_wmask),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mode      (mode)
    );

    ata_route_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .bridge_en  (bridge_en),
        .pad_en     (pad_en),
        .sel        (sel),
        .has_bridge (ctl_has_bridge),
        .br_slave   (bridge_slave),
        .cfg_err    (cfg_err)
    );

    ata_route_xbar #(
        .DATA_W(DATA_W)
    ) u_xbar (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .port_h2d (port_h2d),
        .port_d2h (port_d2h),
        .ep_h2d   (ep_h2d),
        .ep_d2h   (ep_d2h)
    );

endmodule

// File: tb/test_ata_lane_router.sv
module test_ata_lane_router;

    localparam int CLK_PERIOD = 10;
    localparam int W = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_addr = 8'h30;
    logic [31:0]   cfg_wmask = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          bridge_en = 1'b1;
    logic          pad_en = 1'b1;
    logic [4*W-1:0] port_h2d = '0;
    logic [4*W-1:0] port_d2h;
    logic [4*W-1:0] ep_h2d;
    logic [4*W-1:0] ep_d2h = '0;
    logic [1:0]    ctl_has_bridge;
    logic [1:0]    bridge_slave;
    logic          cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int          m_state;   // 0 idle, 1 routing, 2 fault
    logic [31:0] m_ctrl;
    int          m_mode;
    bit          m_br, m_pad;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_lane_router #(.DATA_W(W)) i_ata_lane_router (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wmask(cfg_wmask), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bridge_en(bridge_en), .pad_en(pad_en), .port_h2d(port_h2d),
        .port_d2h(port_d2h), .ep_h2d(ep_h2d), .ep_d2h(ep_d2h),
        .ctl_has_bridge(ctl_has_bridge), .bridge_slave(bridge_slave), .cfg_err(cfg_err)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_ctrl = '0; m_mode = 0; m_br = 0; m_pad = 0;
        end else begin
            m_mode  = int'(m_ctrl[26:24]);
            m_br    = bridge_en;
            m_pad   = pad_en;
            m_state = (m_mode < 4 && (bridge_en || pad_en)) ? 1 : 2;
            if (cfg_wr && cfg_addr == 8'h30)
                m_ctrl = (m_ctrl & ~cfg_wmask) | (cfg_wdata & cfg_wmask);
        end
    end

    // port index: 0 c0m, 1 c0s, 2 c1m, 3 c1s; -1 means unrouted
    function automatic int owner(int ep);
        if (m_state != 1) return -1;
        case (ep)
            0: return m_br ? (m_mode == 2 ? 3 : 0) : -1;
            1: return m_br ? (m_mode == 3 ? 1 : 2) : -1;
            2: return m_pad ? (m_mode == 2 ? 0 : (m_mode == 3 ? 2 : -1)) : -1;
            default: return m_pad ? ((m_mode == 0 || m_mode == 2) ? 1 : 3) : -1;
        endcase
    endfunction

    function automatic string route_tag(int ep);
        if (m_state == 0) return "R2";
        if (m_state == 2) return (m_mode >= 4) ? "R8" : "R9";
        if (ep < 2 && !m_br) return "R10";
        if (ep >= 2 && !m_pad) return "R11";
        case (m_mode)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] exp;
        string tag;
        check("R1", "rdata", cfg_rdata, (cfg_addr == 8'h30) ? m_ctrl : 32'h0);
        tag = (m_state == 0) ? "R2" : ((m_mode >= 4) ? "R8" : "R9");
        check(tag, "err", {31'b0, cfg_err}, {31'b0, m_state == 2});
        exp = (m_state == 1 && m_br) ? {30'b0, m_mode != 3, m_mode != 2} : 32'h0;
        check("R13", "has_bridge", {30'b0, ctl_has_bridge}, exp);
        exp = (m_state == 1 && m_br) ? {30'b0, m_mode == 3, m_mode == 2} : 32'h0;
        check("R13", "slave", {30'b0, bridge_slave}, exp);
        for (int e = 0; e < 4; e++) begin
            int o;
            o = owner(e);
            exp = (o >= 0) ? {22'b0, port_h2d[o*W +: W]} : 32'h0;
            check(route_tag(e), $sformatf("ep_h2d[%0d]", e), {22'b0, ep_h2d[e*W +: W]}, exp);
        end
        for (int p = 0; p < 4; p++) begin
            exp = 32'h0;
            for (int e = 0; e < 4; e++)
                if (owner(e) == p) exp = {22'b0, ep_d2h[e*W +: W]};
            check("R12", $sformatf("port_d2h[%0d]", p), {22'b0, port_d2h[p*W +: W]}, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        compare();
        port_h2d = {$urandom, $urandom};
        ep_d2h   = {$urandom, $urandom};
    endtask

    task automatic write(logic [7:0] a, logic [31:0] mask, logic [31:0] data);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wmask = mask; cfg_wdata = data;
        cycle();
        cfg_wr = 1'b0; cfg_addr = 8'h30;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle();              // R2: reset state compared each cycle
        rst_n = 1'b1;
        cycle();
        cycle();

        // R1: a write elsewhere changes nothing
        write(8'h34, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        cycle();
        check("R1", "foreign write", cfg_rdata, 32'h0);

        // R1: masked writes keep the other bits
        write(8'h30, 32'h00FF_00F0, 32'hA5A5_A5A5);
        write(8'h30, 32'h0700_0000, 32'hFFFF_FFFF);
        cycle();
        check("R1", "masked field", cfg_rdata, 32'h07A5_00A0);
        write(8'h30, 32'h0700_0000, 32'h0000_0000);
        cycle();
        cycle();

        // R3: the new code reaches the outputs one clock after the register
        write(8'h30, 32'h0700_0000, 32'h0200_0000);
        check("R3", "slave before update", {30'b0, bridge_slave}, 32'h0);
        cycle();
        check("R3", "slave after update", {30'b0, bridge_slave}, 32'h1);

        for (int md = 0; md < 8; md++) begin
            for (int en = 0; en < 4; en++) begin
                bridge_en = en[0];
                pad_en    = en[1];
                write(8'h30, 32'h0700_0000, ($urandom & 32'hF8FF_FFFF) | (32'(md) << 24));
                repeat (5) cycle();
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule